// File: doc/BRIEF.md
# Two-Channel Serial Audio Transmitter with Clock Generation

This block drives a stereo serial audio link as bus master. A single divider chain, clocked by the system clock, produces a master clock at 256 times the sample rate, a bit clock with a fixed number of slot bits per channel, and a word-select clock that marks which channel is being sent. Parallel left and right samples are shifted out on one data line, most significant bit first.

The data placement inside each channel half is chosen by a static two-bit format input. Three placements are supported. In the standard one, data starts one bit period after the word-select edge. In the left-aligned one, data starts on that edge. In the right-aligned one, data ends on the last bit period of the half. Samples arrive through a ready/valid handshake into a one-entry holding register. The pair held there is copied into the shifting register when each frame begins. If nothing new is waiting, the previous pair is sent again.

The frame is always 512 master-clock half periods long. `MCLK_HALF` sets how many system clocks make up one master-clock half period. `SLOT_BITS` is a power of two from 8 to 128. `DATA_BITS` must be smaller than `SLOT_BITS`, so that every placement fits inside its own half.

Top module: `ser_audio_tx`

## Requirements
- R1: `mclk_o` toggles every `MCLK_HALF` system clocks, giving exactly 256 master-clock periods per frame.
- R2: Each frame holds 2×`SLOT_BITS` bit-clock periods. `ws_o` is low for the first `SLOT_BITS` of them (left channel) and high for the remaining `SLOT_BITS` (right channel).
- R3: `ws_o` and `sd_o` change only on a falling edge of `bclk_o`, so that a receiver can sample them on the rising edge. Every edge of `bclk_o` coincides with an edge of `mclk_o`.
- R4: With format code 2'b00 (standard), the MSB of each channel occupies bit period 1 of its half, counting from 0 at the word-select transition.
- R5: With format code 2'b01 (left-aligned), the MSB of each channel occupies bit period 0 of its half.
- R6: With format code 2'b10 (right-aligned), the LSB of each channel occupies bit period `SLOT_BITS`-1 of its half.
- R7: Each channel sends `DATA_BITS` bits, MSB first. Every bit period that carries no sample bit is driven low.
- R8: `in_ready` is high exactly when the holding register is empty. A pair is accepted on a clock where `in_valid` and `in_ready` are both high. After an accept, `in_ready` stays low until the next frame start.
- R9: At each frame start (beginning of the left half), a pending pair replaces the pair being sent. With nothing pending, the same pair is sent again, and the pair never changes at any other time.
- R10: `cfg_mode` is sampled only at a frame start. Code 2'b11 behaves as standard.
- R11: During reset the outputs are `mclk_o`=1, `bclk_o`=1, `ws_o`=1, `sd_o`=0 and `in_ready`=1, and the pair being sent is zero. The first frame starts on the first clock after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Data placement: 00 standard, 01 left-aligned, 10 right-aligned, 11 standard |
| in_valid | input | 1 | Sample pair offered |
| in_ready | output | 1 | Holding register empty, pair can be taken |
| in_left | input | DATA_BITS | Left-channel sample |
| in_right | input | DATA_BITS | Right-channel sample |
| mclk_o | output | 1 | Master clock, 256 × sample rate |
| bclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select, low = left channel |
| sd_o | output | 1 | Serial data |

## Verification
The assertions cover the link's timing on every cycle:
- the master-clock half period;
- the equal number of bit periods in each word-select half;
- data and word-select moving only on falling bit-clock edges;
- `in_ready` dropping after an accept and staying low until the next frame;
- the sample pair changing only at a frame start.

Which bits appear where for each format code, the zero fill, the repeating of a stale pair, and the moment a format change takes effect can only be shown by the bench scenarios. The bench decodes those scenarios as a receiver would.

// File: rtl/sat_pkg.sv
package sat_pkg;

    // Data placement codes on cfg_mode
    typedef enum logic [1:0] {
        FMT_STD   = 2'b00,
        FMT_LEFT  = 2'b01,
        FMT_RIGHT = 2'b10,
        FMT_ALT   = 2'b11
    } fmt_e;

    // One frame spans this many master-clock half periods (256 mclk periods)
    localparam int FRAME_HALVES = 512;
    localparam int POS_W        = $clog2(FRAME_HALVES);

    typedef struct packed {
        logic mclk;
        logic bclk;
        logic ws;
        logic sd;
    } pins_t;

    // Bus state that matches the last half period of a frame
    localparam pins_t PINS_IDLE = '{mclk: 1'b1, bclk: 1'b1, ws: 1'b1, sd: 1'b0};

    // Bit period (within a half) that carries the MSB of a channel
    function automatic int slot_offset(fmt_e f, int slot_bits, int data_bits);
        case (f)
            FMT_LEFT:  return 0;
            FMT_RIGHT: return slot_bits - data_bits;
            default:   return 1;
        endcase
    endfunction

endpackage

// File: rtl/sat_clkgen.sv
module sat_clkgen
    import sat_pkg::*;
#(
    parameter int MCLK_HALF = 1
) (
    input  logic             clk,
    input  logic             rst,
    output logic [POS_W-1:0] pos,
    output logic             frame_start
);
    localparam int                PRE_W    = $clog2(MCLK_HALF + 1);
    localparam logic [PRE_W-1:0]  PRE_LAST = PRE_W'(MCLK_HALF - 1);

    logic [PRE_W-1:0] pre;
    logic             step;

    assign step        = (pre == PRE_LAST);
    assign frame_start = step && (pos == '1);

    // Reset parks the chain on the last half period so the next edge opens a frame
    always_ff @(posedge clk) begin
        if (rst) begin
            pre <= PRE_LAST;
            pos <= '1;
        end else if (step) begin
            pre <= '0;
            pos <= pos + 1'b1;
        end else begin
            pre <= pre + 1'b1;
        end
    end

endmodule

// File: rtl/sat_sample_buf.sv
module sat_sample_buf
    import sat_pkg::*;
#(
    parameter int DATA_BITS = 24
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frame_start,
    input  logic [1:0]           cfg_mode,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [DATA_BITS-1:0] in_left,
    input  logic [DATA_BITS-1:0] in_right,
    output logic [DATA_BITS-1:0] act_left,
    output logic [DATA_BITS-1:0] act_right,
    output fmt_e                 act_mode
);
    logic                 pend_valid;
    logic [DATA_BITS-1:0] pend_left;
    logic [DATA_BITS-1:0] pend_right;
    logic                 accept;

    assign in_ready = !pend_valid;
    assign accept   = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_valid <= 1'b0;
            pend_left  <= '0;
            pend_right <= '0;
        end else if (accept) begin
            pend_valid <= 1'b1;
            pend_left  <= in_left;
            pend_right <= in_right;
        end else if (frame_start) begin
            pend_valid <= 1'b0;
        end
    end

    // Pair and format switch only when a frame opens
    always_ff @(posedge clk) begin
        if (rst) begin
            act_left  <= '0;
            act_right <= '0;
            act_mode  <= FMT_STD;
        end else if (frame_start) begin
            act_mode <= fmt_e'(cfg_mode);
            if (pend_valid) begin
                act_left  <= pend_left;
                act_right <= pend_right;
            end
        end
    end

endmodule

// File: rtl/sat_serializer.sv
module sat_serializer
    import sat_pkg::*;
#(
    parameter int SLOT_BITS = 32,
    parameter int DATA_BITS = 24
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [POS_W-1:0]     pos,
    input  logic [DATA_BITS-1:0] act_left,
    input  logic [DATA_BITS-1:0] act_right,
    input  fmt_e                 act_mode,
    output pins_t                pins
);
    // Half periods per bit, as a power of two, and bit index width per frame
    localparam int              LHPB  = $clog2(256 / SLOT_BITS);
    localparam int              LB    = $clog2(2 * SLOT_BITS);
    localparam logic [LB-2:0]   DLAST = (LB-1)'(DATA_BITS - 1);
    localparam logic [LB-2:0]   DLIM  = (LB-1)'(DATA_BITS);

    if (SLOT_BITS < 8 || SLOT_BITS > 128 || (1 << $clog2(SLOT_BITS)) != SLOT_BITS) begin : g_bad_slot
        $error("SLOT_BITS must be a power of two from 8 to 128");
    end
    if (DATA_BITS >= SLOT_BITS || DATA_BITS < 1) begin : g_bad_data
        $error("DATA_BITS must lie between 1 and SLOT_BITS-1");
    end

    logic [LB-1:0]        bit_idx;
    logic [LB-1:0]        offs;
    logic [LB-1:0]        rel;
    logic [LB-2:0]        k;
    logic [LB-2:0]        sel;
    logic [DATA_BITS-1:0] word;
    logic                 data_bit;
    pins_t                nxt;

    always_comb begin
        bit_idx  = pos[POS_W-1:LHPB];
        offs     = LB'(slot_offset(act_mode, SLOT_BITS, DATA_BITS));
        rel      = bit_idx - offs;
        k        = rel[LB-2:0];
        word     = rel[LB-1] ? act_right : act_left;
        sel      = DLAST - k;
        data_bit = (k < DLIM) ? word[sel] : 1'b0;

        nxt.mclk = pos[0];
        nxt.bclk = pos[LHPB-1];
        nxt.ws   = pos[POS_W-1];
        nxt.sd   = data_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) pins <= PINS_IDLE;
        else     pins <= nxt;
    end

endmodule

// File: rtl/ser_audio_tx.sv
module ser_audio_tx
    import sat_pkg::*;
#(
    parameter int SLOT_BITS = 32,
    parameter int DATA_BITS = 24,
    parameter int MCLK_HALF = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           cfg_mode,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [DATA_BITS-1:0] in_left,
    input  logic [DATA_BITS-1:0] in_right,
    output logic                 mclk_o,
    output logic                 bclk_o,
    output logic                 ws_o,
    output logic                 sd_o
);
    logic [POS_W-1:0]     pos;
    logic                 frame_start;
    logic [DATA_BITS-1:0] act_left;
    logic [DATA_BITS-1:0] act_right;
    fmt_e                 act_mode;
    pins_t                pins;

    sat_clkgen #(.MCLK_HALF(MCLK_HALF)) u_clkgen (
        .clk         (clk),
        .rst         (rst),
        .pos         (pos),
        .frame_start (frame_start)
    );

    sat_sample_buf #(.DATA_BITS(DATA_BITS)) u_buf (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .cfg_mode    (cfg_mode),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_left     (in_left),
        .in_right    (in_right),
        .act_left    (act_left),
        .act_right   (act_right),
        .act_mode    (act_mode)
    );

    sat_serializer #(.SLOT_BITS(SLOT_BITS), .DATA_BITS(DATA_BITS)) u_ser (
        .clk       (clk),
        .rst       (rst),
        .pos       (pos),
        .act_left  (act_left),
        .act_right (act_right),
        .act_mode  (act_mode),
        .pins      (pins)
    );

    assign mclk_o = pins.mclk;
    assign bclk_o = pins.bclk;
    assign ws_o   = pins.ws;
    assign sd_o   = pins.sd;

endmodule

// File: rtl/sat_checker.sv
module sat_checker #(
    parameter int SLOT_BITS = 32,
    parameter int DATA_BITS = 24,
    parameter int MCLK_HALF = 1
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 mclk_o,
    input logic                 bclk_o,
    input logic                 ws_o,
    input logic                 sd_o,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic                 frame_start,
    input logic [DATA_BITS-1:0] act_left,
    input logic [DATA_BITS-1:0] act_right
);
    logic m_prev, b_prev, w_prev;
    logic m_seen, w_seen;
    int   m_cnt, bf_cnt;
    logic m_chg, w_chg, b_fall;

    assign m_chg  = (mclk_o != m_prev);
    assign w_chg  = (ws_o != w_prev);
    assign b_fall = b_prev && !bclk_o;

    always_ff @(posedge clk) begin
        m_prev <= mclk_o;
        b_prev <= bclk_o;
        w_prev <= ws_o;
        if (rst) begin
            m_cnt  <= 0;
            m_seen <= 1'b0;
            bf_cnt <= 0;
            w_seen <= 1'b0;
        end else begin
            if (m_chg) begin
                m_cnt  <= 0;
                m_seen <= 1'b1;
            end else begin
                m_cnt <= m_cnt + 1;
            end
            if (w_chg) begin
                bf_cnt <= 0;
                w_seen <= 1'b1;
            end else if (b_fall) begin
                bf_cnt <= bf_cnt + 1;
            end
        end
    end

    assert_mclk_half_R1: assert property (@(posedge clk) disable iff (rst)
        (m_chg && m_seen) |-> (m_cnt == MCLK_HALF - 1));

    assert_mclk_bound_R1: assert property (@(posedge clk) disable iff (rst)
        m_seen |-> (m_cnt <= MCLK_HALF - 1));

    assert_ws_square_R2: assert property (@(posedge clk) disable iff (rst)
        (w_chg && w_seen) |-> (bf_cnt == SLOT_BITS - 1));

    assert_ws_on_fall_R3: assert property (@(posedge clk) disable iff (rst)
        (ws_o != $past(ws_o)) |-> ($past(bclk_o) && !bclk_o));

    assert_sd_on_fall_R3: assert property (@(posedge clk) disable iff (rst)
        (sd_o != $past(sd_o)) |-> ($past(bclk_o) && !bclk_o));

    assert_bclk_with_mclk_R3: assert property (@(posedge clk) disable iff (rst)
        (bclk_o != $past(bclk_o)) |-> (mclk_o != $past(mclk_o)));

    assert_ready_drop_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    assert_ready_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!in_ready && !frame_start) |=> !in_ready);

    assert_pair_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable({act_left, act_right}));

endmodule

bind ser_audio_tx sat_checker #(
    .SLOT_BITS (SLOT_BITS),
    .DATA_BITS (DATA_BITS),
    .MCLK_HALF (MCLK_HALF)
) u_sat_checker (
    .clk         (clk),
    .rst         (rst),
    .mclk_o      (mclk_o),
    .bclk_o      (bclk_o),
    .ws_o        (ws_o),
    .sd_o        (sd_o),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .frame_start (frame_start),
    .act_left    (act_left),
    .act_right   (act_right)
);

// File: tb/test_ser_audio_tx.sv
module test_ser_audio_tx;
    localparam int S         = 32;
    localparam int D         = 24;
    localparam int MH        = 2;
    localparam int FRAME_CYC = 512 * MH;
    localparam int WATCHDOG  = 150000;

    typedef struct packed {
        logic [D-1:0] l;
        logic [D-1:0] r;
    } pair_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   cfg_mode = 2'b00;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [D-1:0] in_left = '0;
    logic [D-1:0] in_right = '0;
    logic         mclk_o, bclk_o, ws_o, sd_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    pair_t exp_q[$];
    event  frame_ev;

    always #2 clk = ~clk;

    ser_audio_tx #(.SLOT_BITS(S), .DATA_BITS(D), .MCLK_HALF(MH)) i_ser_audio_tx (
        .clk      (clk),
        .rst      (rst),
        .cfg_mode (cfg_mode),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_left  (in_left),
        .in_right (in_right),
        .mclk_o   (mclk_o),
        .bclk_o   (bclk_o),
        .ws_o     (ws_o),
        .sd_o     (sd_o)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected line content of one frame, bit period p from the left-half start
    function automatic logic [63:0] frame_bits(input logic [1:0] md, input pair_t pr);
        logic [63:0] v = '0;
        int off = (md == 2'b01) ? 0 : (md == 2'b10) ? (S - D) : 1;
        for (int p = 0; p < 2 * S; p++) begin
            int k = (p % S) - off;
            logic [D-1:0] w = (p >= S) ? pr.r : pr.l;
            if (k >= 0 && k < D) v[p] = w[D-1-k];
        end
        return v;
    endfunction

    // Receiver-style monitor and scoreboard
    logic        prev_b, prev_m, rx_ws_prev, started;
    int          nbits, nleft, mrises, cyc;
    logic [63:0] got;
    logic [1:0]  frame_mode;
    pair_t       cur;

    always @(negedge clk) begin
        if (rst) begin
            prev_b = 1'b1; prev_m = 1'b1; rx_ws_prev = 1'b1; started = 1'b0;
            nbits = 0; nleft = 0; mrises = 0; cyc = 0; got = '0;
            cur = '0; frame_mode = 2'b00;
        end else if (!done) begin
            cyc++;
            if (mclk_o && !prev_m) mrises++;
            if (bclk_o && !prev_b) begin
                if (!ws_o && rx_ws_prev) begin
                    if (started) begin
                        check(nbits == 2 * S && nleft == S, "R2 bit periods per frame / left half",
                              64'(nbits * 1000 + nleft), 64'(2 * S * 1000 + S));
                        check(mrises == 256 && cyc == FRAME_CYC, "R1 mclk periods / cycles per frame",
                              64'(mrises * 100000 + cyc), 64'(256 * 100000 + FRAME_CYC));
                        check(got == frame_bits(frame_mode, cur),
                              (frame_mode == 2'b01) ? "R5 R7 R9 left-aligned frame" :
                              (frame_mode == 2'b10) ? "R6 R7 R9 right-aligned frame" :
                              (frame_mode == 2'b11) ? "R10 R4 R7 R9 code 11 frame" :
                                                      "R4 R7 R9 standard frame",
                              got, frame_bits(frame_mode, cur));
                    end
                    if (exp_q.size() > 0) cur = exp_q.pop_front();
                    frame_mode = cfg_mode;
                    started = 1'b1;
                    nbits = 0; nleft = 0; mrises = 0; cyc = 0; got = '0;
                    -> frame_ev;
                end
                if (nbits < 2 * S) got[nbits] = sd_o;
                if (!ws_o) nleft++;
                nbits++;
                rx_ws_prev = ws_o;
            end
            prev_b = bclk_o;
            prev_m = mclk_o;
        end
    end

    // Driver: offer a pair, push it to the scoreboard when taken
    task automatic send(input logic [D-1:0] l, input logic [D-1:0] r);
        @(negedge clk);
        in_valid = 1'b1; in_left = l; in_right = r;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        exp_q.push_back('{l: l, r: r});
        @(negedge clk);
        in_valid = 1'b0;
        check(in_ready == 1'b0, "R8 in_ready low after accept", 64'(in_ready), 64'(0));
    endtask

    task automatic wait_frames(input int n);
        repeat (n) @(frame_ev);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        check({mclk_o, bclk_o, ws_o, sd_o, in_ready} == 5'b11101, "R11 reset outputs",
              64'({mclk_o, bclk_o, ws_o, sd_o, in_ready}), 64'(5'b11101));
        rst = 1'b0;
        @(frame_ev);
        // R4, R8, R9: standard framing, back-to-back pairs, then repeats
        send(24'hA5C31F, 24'h3C0F81);
        send(24'h800001, 24'h7FFFFE);
        send(24'h123456, 24'hFEDCBA);
        wait_frames(3);
        // R5, R10: switch to left-aligned at a frame boundary
        cfg_mode = 2'b01;
        send(24'hFFFFFF, 24'h000000);
        send(24'h555555, 24'hAAAAAA);
        wait_frames(2);
        // R6: right-aligned
        cfg_mode = 2'b10;
        send(24'h000001, 24'h800000);
        send(24'hC0FFEE, 24'h0BADF0);
        wait_frames(2);
        // R10: code 11 behaves as standard
        cfg_mode = 2'b11;
        send(24'h9E3779, 24'h61C886);
        wait_frames(3);
        finish_run();
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=<%0d cycles", WATCHDOG, WATCHDOG);
        finish_run();
    end

endmodule